// File: doc/BRIEF.md
# Host Word Swap Bus Adapter

This block sits between a host data bus and a set of internal 32-bit targets: a register port and a pair of data streams, one for transmit and one for receive. The host bus runs either 32 bits wide or 16 bits wide, and a plain `mode32` input selects which. In 16-bit mode one address bit (`host_req_a1`) picks which half of the internal word an access touches. A 32-bit swap register inside the adapter decides how that bit maps onto the two halves.

Transmit data written 16 bits at a time is gathered into one 32-bit word before a single push. Each receive word popped in 16-bit mode is split into two 16-bit reads. The low-order half of a stream word always travels first. The swap setting therefore also decides which value of the address bit has to come first.

Host requests use a valid/ready handshake. `host_req_ready` may be low only for an access that completes a transmit word while `tx_ready` is low, or for an access that pops receive data while `rx_valid` is low. The host must hold the request stable until it is accepted. Every other access is accepted in the cycle it is presented. Read data returns on `host_rsp_valid` exactly one cycle after the read is accepted, and the host must take it then because the response channel has no back-pressure. The transmit side follows the usual stream rule: `tx_valid` does not wait for `tx_ready`, and data is held until both are high.

Top module: `hbus_swap_adapter`

## Requirements
- R1: With `mode32`=1 the swap setting has no effect. A register write drives `reg_be`=4'b1111 with the host word unchanged. A stream write pushes the host word as it is. A read returns the full 32-bit word.
- R2: The swap register lives at register index `SWAP_ADDR` (default 8'h1D) and resets to 32'h0000_0000. It is read and written through the register path, with byte enables. Accesses to it never reach `reg_wr_en`/`reg_rd_en`. Swapping is active only while it holds exactly 32'hFFFF_FFFF, and any other value (32'h0000_FFFF, 32'hFFFF_FFFE, and so on) gives the default mapping.
- R3: In 16-bit mode with swapping off, `host_req_a1`=0 selects the low half (bits 15:0, `reg_be`=4'b0011) and `host_req_a1`=1 selects the high half (bits 31:16, `reg_be`=4'b1100). The 16-bit value is taken from `host_req_wdata[15:0]` and driven on both halves of `reg_wdata`.
- R4: In 16-bit mode with swapping on, the mapping is reversed: `host_req_a1`=0 selects the high half and `host_req_a1`=1 selects the low half.
- R5: A 16-bit stream write to the low half is staged and produces no push. A 16-bit stream write to the high half raises `tx_valid` with `tx_data` = {high value, staged low value}.
- R6: A 16-bit stream read of the low half pops a receive word (`rx_ready`) and returns its bits 15:0. A read of the high half returns bits 31:16 of the last popped word and does not pop.
- R7: An access that pushes waits for `tx_ready`, and an access that pops waits for `rx_valid`. All other accesses have `host_req_ready`=1.
- R8: `host_rsp_valid` is high exactly in the cycle after a read is accepted. In 16-bit mode the selected half sits in `host_rsp_rdata[15:0]` with bits 31:16 at zero.
- R9: A register read to an index other than `SWAP_ADDR` raises `reg_rd_en` in the accept cycle and captures `reg_rdata` from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1: 32-bit host bus, 0: 16-bit host bus |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted this cycle |
| host_req_write | input | 1 | 1 write, 0 read |
| host_req_fifo | input | 1 | 1 stream window, 0 register window |
| host_req_a1 | input | 1 | Half select in 16-bit mode |
| host_req_addr | input | AW | Register index |
| host_req_wdata | input | DW | Write data (bits 15:0 in 16-bit mode) |
| host_rsp_valid | output | 1 | Read data valid |
| host_rsp_rdata | output | DW | Read data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | AW | Register index |
| reg_be | output | DW/8 | Register byte enables |
| reg_wdata | output | DW | Register write data |
| reg_rdata | input | DW | Register read data, combinational |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Transmit stream can take a word |
| tx_data | output | DW | Transmit word |
| rx_valid | input | 1 | Receive word available |
| rx_ready | output | 1 | Pop receive word |
| rx_data | input | DW | Receive word |

## Verification
The bench writes the swap register one half at a time, so it passes through 32'h0000_FFFF before it reaches all-ones. A design that swapped on any nonzero value, or on a single set bit, would reverse the halves early. Transmit and receive are exercised in both orders of the address bit under both settings. Getting the completing half wrong would push a word built from a stale staged half or pop twice per word, and that shows up as shifted stream data. Stall patterns on `tx_ready` and `rx_valid` test that acceptance waits only for the pushing or popping access. The bench also returns to 32-bit mode with the swap set to all-ones: a design that left swapping active there would move the byte enables and reorder the stream words.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

  // Source of the word captured for a read response
  typedef enum logic [1:0] {
    RD_REG  = 2'd0,
    RD_SWAP = 2'd1,
    RD_FIFO = 2'd2
  } rd_src_e;

  // True when a 16-bit access lands on the upper half of the internal word
  function automatic logic upper_half(input logic wide, input logic swap_on,
                                      input logic a1);
    return !wide && (a1 ^ swap_on);
  endfunction

endpackage

// File: rtl/hsa_lane_map.sv
module hsa_lane_map #(
  parameter int DW = 32
) (
  input  logic            wide,
  input  logic            hi_sel,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   rword,
  output logic [DW/8-1:0] be,
  output logic [DW-1:0]   wmap,
  output logic [DW-1:0]   rnarrow
);
  localparam int HW  = DW / 2;
  localparam int BEW = DW / 8;

  // Byte enables: all lanes when wide, otherwise one half picked by hi_sel
  for (genvar g = 0; g < BEW; g++) begin : g_be
    if (g >= BEW / 2) begin : g_upper
      assign be[g] = wide | hi_sel;
    end else begin : g_lower
      assign be[g] = wide | ~hi_sel;
    end
  end

  // Narrow write data is replicated so either half carries it
  assign wmap = wide ? wdata : {wdata[HW-1:0], wdata[HW-1:0]};

  // Narrow read returns the selected half in the low lanes
  always_comb begin
    if (wide) begin
      rnarrow = rword;
    end else if (hi_sel) begin
      rnarrow = {{HW{1'b0}}, rword[DW-1:HW]};
    end else begin
      rnarrow = {{HW{1'b0}}, rword[HW-1:0]};
    end
  end

endmodule

// File: rtl/hsa_swap_reg.sv
module hsa_swap_reg #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   value,
  output logic            swap_on
);
  localparam int BEW = DW / 8;

  for (genvar g = 0; g < BEW; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        value[8*g +: 8] <= 8'h00;
      end else if (wr_en && be[g]) begin
        value[8*g +: 8] <= wdata[8*g +: 8];
      end
    end
  end

  // Only the exact all-ones pattern turns swapping on
  assign swap_on = &value;

endmodule

// File: rtl/hsa_tx_pack.sv
module hsa_tx_pack #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          hi_sel,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          wr_ready
);
  localparam int HW = DW / 2;

  logic [HW-1:0] low_q;
  logic          completes;

  // A wide write or the upper half closes a word
  assign completes = wide | hi_sel;
  assign tx_valid  = wr_req & completes;
  assign tx_data   = wide ? wdata : {wdata[HW-1:0], low_q};
  assign wr_ready  = completes ? tx_ready : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (wr_req && !completes) begin
      low_q <= wdata[HW-1:0];
    end
  end

endmodule

// File: rtl/hsa_rx_split.sv
module hsa_rx_split #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          hi_sel,
  input  logic          rd_req,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rd_ready,
  output logic [DW-1:0] rd_word
);
  localparam int HW = DW / 2;

  logic [HW-1:0] hold_q;
  logic          pops;

  // A wide read or the lower half fetches a new word
  assign pops     = wide | ~hi_sel;
  assign rx_ready = rd_req & pops;
  assign rd_ready = pops ? rx_valid : 1'b1;
  assign rd_word  = pops ? rx_data : {hold_q, {HW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (rd_req && pops && rx_valid && !wide) begin
      hold_q <= rx_data[DW-1:HW];
    end
  end

endmodule

// File: rtl/hbus_swap_adapter.sv
module hbus_swap_adapter
  import hsa_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int SWAP_ADDR = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode32,
  input  logic            host_req_valid,
  output logic            host_req_ready,
  input  logic            host_req_write,
  input  logic            host_req_fifo,
  input  logic            host_req_a1,
  input  logic [AW-1:0]   host_req_addr,
  input  logic [DW-1:0]   host_req_wdata,
  output logic            host_rsp_valid,
  output logic [DW-1:0]   host_rsp_rdata,
  output logic            reg_wr_en,
  output logic            reg_rd_en,
  output logic [AW-1:0]   reg_addr,
  output logic [DW/8-1:0] reg_be,
  output logic [DW-1:0]   reg_wdata,
  input  logic [DW-1:0]   reg_rdata,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data
);
  localparam int BEW = DW / 8;
  localparam logic [AW-1:0] SWAP_IDX = AW'(SWAP_ADDR);

  logic            swap_on;
  logic [DW-1:0]   swap_q;
  logic            hi_sel;
  logic            hit_swap;
  logic            fifo_wr, fifo_rd, reg_req;
  logic            wr_ready, rd_ready;
  logic [DW-1:0]   rx_word;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rd_narrow;
  logic [BEW-1:0]  be_map;
  logic [DW-1:0]   wdata_map;
  logic            rd_acc;
  rd_src_e         rd_src;

  assign hi_sel   = upper_half(mode32, swap_on, host_req_a1);
  assign hit_swap = (host_req_addr == SWAP_IDX);
  assign fifo_wr  = host_req_valid &  host_req_write &  host_req_fifo;
  assign fifo_rd  = host_req_valid & ~host_req_write &  host_req_fifo;
  assign reg_req  = host_req_valid & ~host_req_fifo;

  hsa_lane_map #(.DW(DW)) u_map (
    .wide    (mode32),
    .hi_sel  (hi_sel),
    .wdata   (host_req_wdata),
    .rword   (rd_mux),
    .be      (be_map),
    .wmap    (wdata_map),
    .rnarrow (rd_narrow)
  );

  hsa_swap_reg #(.DW(DW)) u_swap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_req & host_req_write & hit_swap),
    .be      (be_map),
    .wdata   (wdata_map),
    .value   (swap_q),
    .swap_on (swap_on)
  );

  hsa_tx_pack #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (mode32),
    .hi_sel   (hi_sel),
    .wr_req   (fifo_wr),
    .wdata    (host_req_wdata),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .wr_ready (wr_ready)
  );

  hsa_rx_split #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (mode32),
    .hi_sel   (hi_sel),
    .rd_req   (fifo_rd),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .rd_ready (rd_ready),
    .rd_word  (rx_word)
  );

  // Register window
  assign reg_wr_en = reg_req &  host_req_write & ~hit_swap;
  assign reg_rd_en = reg_req & ~host_req_write & ~hit_swap;
  assign reg_addr  = host_req_addr;
  assign reg_be    = be_map;
  assign reg_wdata = wdata_map;

  // Acceptance
  always_comb begin
    if (host_req_fifo) begin
      host_req_ready = host_req_write ? wr_ready : rd_ready;
    end else begin
      host_req_ready = 1'b1;
    end
  end

  // Read source select
  always_comb begin
    if (host_req_fifo)  rd_src = RD_FIFO;
    else if (hit_swap)  rd_src = RD_SWAP;
    else                rd_src = RD_REG;
  end

  always_comb begin
    case (rd_src)
      RD_FIFO: rd_mux = rx_word;
      RD_SWAP: rd_mux = swap_q;
      default: rd_mux = reg_rdata;
    endcase
  end

  assign rd_acc = host_req_valid & host_req_ready & ~host_req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
    end else begin
      host_rsp_valid <= rd_acc;
      if (rd_acc) begin
        host_rsp_rdata <= rd_narrow;
      end
    end
  end

endmodule

// File: rtl/hsa_checks.sv
module hsa_checks #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int SWAP_ADDR = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode32,
  input logic            swap_on,
  input logic            host_req_valid,
  input logic            host_req_ready,
  input logic            host_req_write,
  input logic            host_req_a1,
  input logic            host_rsp_valid,
  input logic            reg_wr_en,
  input logic            reg_rd_en,
  input logic [AW-1:0]   reg_addr,
  input logic [DW/8-1:0] reg_be,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic            rx_ready
);
  localparam int BEW = DW / 8;
  localparam logic [BEW-1:0] BE_LO = {(BEW/2){1'b1}};
  localparam logic [BEW-1:0] BE_HI = BE_LO << (BEW / 2);
  localparam logic [AW-1:0]  SWAP_IDX = AW'(SWAP_ADDR);

  p_be_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && mode32 |-> reg_be == {BEW{1'b1}});

  p_swap_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> reg_addr != SWAP_IDX);

  p_be_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !mode32 && !swap_on |-> reg_be == (host_req_a1 ? BE_HI : BE_LO));

  p_be_swapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !mode32 && swap_on |-> reg_be == (host_req_a1 ? BE_LO : BE_HI));

  p_push_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !mode32 |-> (host_req_a1 ^ swap_on));

  p_pop_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !mode32 |-> !(host_req_a1 ^ swap_on));

  p_tx_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |-> !host_req_ready);

  p_rx_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_valid |-> !host_req_ready);

  p_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && !host_req_write |=> host_rsp_valid);

  p_rsp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req_valid && host_req_ready && !host_req_write) |=> !host_rsp_valid);

  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, reg_rd_en, tx_valid, rx_ready}));

endmodule

bind hbus_swap_adapter hsa_checks #(.DW(DW), .AW(AW), .SWAP_ADDR(SWAP_ADDR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode32         (mode32),
  .swap_on        (swap_on),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_req_write (host_req_write),
  .host_req_a1    (host_req_a1),
  .host_rsp_valid (host_rsp_valid),
  .reg_wr_en      (reg_wr_en),
  .reg_rd_en      (reg_rd_en),
  .reg_addr       (reg_addr),
  .reg_be         (reg_be),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .rx_valid       (rx_valid),
  .rx_ready       (rx_ready)
);

// File: tb/hbus_swap_adapter_tb_top.sv
`timescale 1ns/1ps
module hbus_swap_adapter_tb_top;
  localparam logic [7:0] SWAP_A = 8'h1D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode32 = 1'b1;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic        host_req_fifo = 1'b0;
  logic        host_req_a1 = 1'b0;
  logic [7:0]  host_req_addr = 8'h00;
  logic [31:0] host_req_wdata = 32'h0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_data = 32'h0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rf(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd1};
  endfunction

  assign reg_rdata = rf(reg_addr);

  hbus_swap_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .mode32(mode32),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_fifo(host_req_fifo),
    .host_req_a1(host_req_a1), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_rdata(host_rsp_rdata), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model state
  logic [31:0] m_swap;
  logic [15:0] m_low, m_hold;
  logic        m_rsp_v;
  logic [31:0] m_rsp_d;
  string       m_rsp_tag;
  logic [31:0] rxq[$];

  // Expectations formed mid-cycle
  logic        e_ready, e_txv, e_rxr, e_hi, e_pops, e_comp;
  logic [3:0]  e_be;
  string       e_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      logic m32, swp, v, w, f, hsw;
      m32 = mode32;
      swp = (m_swap == 32'hFFFF_FFFF) && !m32;
      v = host_req_valid; w = host_req_write; f = host_req_fifo;
      hsw = (host_req_addr == SWAP_A);
      e_hi = !m32 && (host_req_a1 ^ swp);
      e_comp = m32 || e_hi;
      e_pops = m32 || !e_hi;
      e_txv = v && w && f && e_comp;
      e_rxr = v && !w && f && e_pops;
      e_be = m32 ? 4'hF : (e_hi ? 4'hC : 4'h3);
      e_tag = m32 ? "R1" : (swp ? "R4" : "R3");
      if (e_txv)      e_ready = tx_ready;
      else if (e_rxr) e_ready = rx_valid;
      else            e_ready = 1'b1;

      if (v) chk("R7", "host_req_ready", 32'(host_req_ready), 32'(e_ready));
      chk("R5", "tx_valid", 32'(tx_valid), 32'(e_txv));
      if (e_txv)
        chk(m32 ? "R1" : "R5", "tx_data", tx_data,
            m32 ? host_req_wdata : {host_req_wdata[15:0], m_low});
      chk("R6", "rx_ready", 32'(rx_ready), 32'(e_rxr));
      chk(hsw ? "R2" : "R9", "reg_wr_en", 32'(reg_wr_en), 32'(v && w && !f && !hsw));
      chk(hsw ? "R2" : "R9", "reg_rd_en", 32'(reg_rd_en), 32'(v && !w && !f && !hsw));
      if (v && w && !f && !hsw) begin
        chk(e_tag, "reg_be", 32'(reg_be), 32'(e_be));
        chk(e_tag, "reg_wdata", reg_wdata,
            m32 ? host_req_wdata : {host_req_wdata[15:0], host_req_wdata[15:0]});
      end
      chk("R8", "host_rsp_valid", 32'(host_rsp_valid), 32'(m_rsp_v));
      if (m_rsp_v) chk(m_rsp_tag, "host_rsp_rdata", host_rsp_rdata, m_rsp_d);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_swap = 32'h0; m_low = 16'h0; m_hold = 16'h0;
      m_rsp_v = 1'b0; m_rsp_d = 32'h0; m_rsp_tag = "R8";
    end else begin
      logic [31:0] word;
      logic m32;
      m32 = mode32;
      m_rsp_v = 1'b0;
      if (host_req_valid && e_ready) begin
        if (host_req_write) begin
          if (host_req_fifo && !e_comp) m_low = host_req_wdata[15:0];
          if (!host_req_fifo && host_req_addr == SWAP_A) begin
            for (int b = 0; b < 4; b++)
              if (e_be[b])
                m_swap[8*b +: 8] = m32 ? host_req_wdata[8*b +: 8]
                                       : host_req_wdata[8*(b%2) +: 8];
          end
        end else begin
          m_rsp_v = 1'b1;
          if (host_req_fifo) begin
            m_rsp_tag = m32 ? "R1" : "R6";
            if (m32) m_rsp_d = rx_data;
            else if (e_pops) begin
              m_rsp_d = {16'h0, rx_data[15:0]};
              m_hold = rx_data[31:16];
            end else m_rsp_d = {16'h0, m_hold};
          end else begin
            word = (host_req_addr == SWAP_A) ? m_swap : rf(host_req_addr);
            m_rsp_tag = (host_req_addr == SWAP_A) ? "R2" : "R9";
            if (m32) m_rsp_d = word;
            else m_rsp_d = {16'h0, e_hi ? word[31:16] : word[15:0]};
          end
        end
      end
      if (e_rxr && rx_valid && rxq.size() != 0) void'(rxq.pop_front());
    end
    cyc++;
    #2;
    tx_ready = (cyc % 3) != 2;
    rx_valid = (rxq.size() != 0) && ((cyc % 4) != 1);
    rx_data  = (rxq.size() != 0) ? rxq[0] : 32'h0;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic req(input logic w, input logic f, input logic a1,
                     input logic [7:0] a, input logic [31:0] d);
    logic acc;
    host_req_write = w; host_req_fifo = f; host_req_a1 = a1;
    host_req_addr = a; host_req_wdata = d; host_req_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = host_req_ready;
      @(posedge clk);
      #1;
    end
    host_req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 10; i++) rxq.push_back(32'hA1B2_C3D4 + i * 32'h0101_0101);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R2 reset value of swap register, R1 wide accesses, R9 register read
    req(0, 0, 0, SWAP_A, 32'h0);
    req(1, 0, 0, 8'h04, 32'h1122_3344);
    req(0, 0, 0, 8'h04, 32'h0);
    req(1, 1, 0, 8'h00, 32'hCAFE_0001);
    req(1, 1, 1, 8'h00, 32'hCAFE_0002);
    req(0, 1, 0, 8'h00, 32'h0);
    req(0, 1, 0, 8'h00, 32'h0);

    // R3 default narrow mapping
    mode32 = 1'b0;
    req(1, 0, 0, 8'h08, 32'h0000_BEEF);
    req(1, 0, 1, 8'h08, 32'h0000_F00D);
    req(0, 0, 0, 8'h08, 32'h0);
    req(0, 0, 1, 8'h08, 32'h0);
    // R5 staging and push, R7 stalls
    req(1, 1, 0, 8'h00, 32'h0000_1111);
    req(1, 1, 1, 8'h00, 32'h0000_2222);
    req(1, 1, 0, 8'h00, 32'h0000_3333);
    idle(2);
    req(1, 1, 1, 8'h00, 32'h0000_4444);
    // R6 pop then held half
    for (int k = 0; k < 2; k++) begin
      req(0, 1, 0, 8'h00, 32'h0);
      req(0, 1, 1, 8'h00, 32'h0);
    end

    // R2 half-written swap value stays inactive
    req(1, 0, 0, SWAP_A, 32'h0000_FFFF);
    req(0, 0, 0, SWAP_A, 32'h0);
    req(0, 0, 1, SWAP_A, 32'h0);
    req(1, 1, 0, 8'h00, 32'h0000_5555);
    req(1, 1, 1, 8'h00, 32'h0000_6666);
    req(1, 0, 1, SWAP_A, 32'h0000_FFFF);

    // R4 swapped mapping
    req(1, 0, 0, 8'h10, 32'h0000_ABCD);
    req(1, 0, 1, 8'h10, 32'h0000_1234);
    req(0, 0, 0, 8'h10, 32'h0);
    req(0, 0, 1, 8'h10, 32'h0);
    req(1, 1, 1, 8'h00, 32'h0000_7777);
    req(1, 1, 0, 8'h00, 32'h0000_8888);
    req(0, 1, 1, 8'h00, 32'h0);
    req(0, 1, 0, 8'h00, 32'h0);
    req(0, 0, 0, SWAP_A, 32'h0);

    // R1 swap ignored in wide mode
    mode32 = 1'b1;
    req(1, 0, 0, 8'h20, 32'hDEAD_BEEF);
    req(1, 1, 1, 8'h00, 32'h9999_AAAA);
    req(0, 1, 1, 8'h00, 32'h0);
    req(0, 0, 0, SWAP_A, 32'h0);
    req(1, 0, 0, SWAP_A, 32'hFFFF_FFFE);

    // R2 near all-ones gives default mapping again
    mode32 = 1'b0;
    req(1, 1, 0, 8'h00, 32'h0000_BBBB);
    req(1, 1, 1, 8'h00, 32'h0000_CCCC);
    req(0, 1, 0, 8'h00, 32'h0);
    req(0, 1, 1, 8'h00, 32'h0);
    req(1, 0, 0, 8'h30, 32'h0000_0F0F);

    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule